// File: doc/BRIEF.md
# Ultra-Low-Power Mode Sequencer

This block decides when a chip drops into its ultra-low-power (ULP) state and when it comes back. Software first arms it through a byte-wide control register, choosing LCD retention, port-match wake-up or both. From then on, two external pins take over: a chip-select pin and a power-request pin. A rising transition on either pin, while the block is armed, turns the internal regulator enable off. A later falling transition on either pin turns the regulator back on. An armed port-match input can also bring the chip back. It wakes on a rising or a falling transition, whichever the polarity bit selects.

An optional oscillator-stop bit lets the block go one step deeper. It counts a fixed number of slow real-time-clock ticks after entry, then drops the oscillator enable and enters shutdown. When the block leaves shutdown, it restarts the oscillator one cycle before it restores the regulator. On every wake, the two arming bits clear themselves, so each sleep has to be armed again. All three asynchronous inputs pass through two-flop synchronizers before their edges are detected. The `rtc_tick` input is a single-cycle pulse that is already in the `clk` domain.

Top module: `lps_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `reg_en`=1, `osc_en`=1, `lcd_lp_en`=0, `mode`=00 and `cfg_err`=0.
- R2: `rd_data` shows bit 4 = oscillator-stop, bit 3 = LCD arm, bit 1 = port-match arm and bit 0 = wake polarity. Bits 7:5 and bit 2 always read 0, and writes to them have no effect.
- R3: A write with bit 4 set while bits 3 and 1 are both clear changes no bit. In this case `cfg_err` is 1 for the single cycle after the write.
- R4: A write that sets bit 3 or bit 1 and also carries a bit 0 that differs from the stored polarity keeps the old polarity and stores the other fields. It also pulses `cfg_err` for one cycle.
- R5: In normal mode, a rising transition on `sel_pin` or `req_pin` drives `reg_en` to 0 and `mode` to 01, provided bit 3 or bit 1 is set. When neither arm bit is set, such a transition has no effect.
- R6: In ULP or shutdown, a falling transition on `sel_pin` or `req_pin` returns the block to normal mode: `mode`=00 and `reg_en`=1.
- R7: On return to normal mode, bits 3 and 1 read 0. Bits 4 and 0 keep their values.
- R8: With bit 1 set, a port-match transition wakes the block like a pin falling edge. With polarity 0 the wake comes on a rising `pm_in` transition, and with polarity 1 on a falling one. The opposite transition does not wake the block, and no `pm_in` transition wakes it when bit 1 is clear.
- R9: `lcd_lp_en` is 1 exactly while the block is out of normal mode with bit 3 set.
- R10: With bit 4 set, the second `rtc_tick` after ULP entry moves the block to shutdown: `mode`=10 and `osc_en`=0.
- R11: On leaving shutdown, `osc_en` returns to 1 one clock before `reg_en` returns to 1. During that one clock, `mode` reads 01.
- R12: Register writes made outside normal mode are ignored.
- R13: A pin change reaches the outputs on the third rising clock edge after it is applied, and not on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sel_pin | input | 1 | Chip-select pin, asynchronous |
| req_pin | input | 1 | Power-request pin, asynchronous |
| pm_in | input | 1 | Port-match input, asynchronous |
| rtc_tick | input | 1 | One-cycle pulse per slow RTC clock |
| reg_en | output | 1 | Regulator enable |
| osc_en | output | 1 | RTC oscillator enable |
| lcd_lp_en | output | 1 | LCD enabled in low-power state |
| mode | output | 2 | 00 normal, 01 ULP, 10 shutdown |
| cfg_err | output | 1 | One-cycle flag for a rejected or altered write |

## Verification
Register results (`rd_data` and `cfg_err`) are due one edge after the write. The bench therefore reads them at the falling edge that follows the strobe. Pin-driven results pass through a synchronizer and an edge register before the state register, so they land on the third rising edge. For R13, the bench samples at the second falling edge to confirm nothing has moved yet, then at the third to see the change. Tick-driven and wake-sequencing results settle one edge after their cause. The bench samples each of them at the following falling edge, one cycle at a time.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LP   = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } lps_state_e;

  localparam int CFG_W     = 8;
  localparam int B_POL     = 0;
  localparam int B_PM_ARM  = 1;
  localparam int B_LCD_ARM = 3;
  localparam int B_OSC_OFF = 4;

  localparam logic [1:0] MODE_RUN = 2'b00;
  localparam logic [1:0] MODE_LP  = 2'b01;
  localparam logic [1:0] MODE_OFF = 2'b10;
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], d[i]};
        last  <= chain[STAGES-1];
      end
    end
    assign rise[i] = chain[STAGES-1] & ~last;
    assign fall[i] = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/lps_cfg.sv
module lps_cfg
  import lps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             allow_wr,
  input  logic             clr_arms,
  output logic [CFG_W-1:0] rd_data,
  output logic             osc_off,
  output logic             lcd_arm,
  output logic             pm_arm,
  output logic             pm_pol,
  output logic             cfg_err
);
  logic new_arm, bad_osc, bad_pol, do_wr;

  assign new_arm = wr_data[B_LCD_ARM] | wr_data[B_PM_ARM];
  assign bad_osc = wr_data[B_OSC_OFF] & ~new_arm;
  assign bad_pol = new_arm & (wr_data[B_POL] != pm_pol);
  assign do_wr   = wr_en & allow_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_off <= 1'b0;
      lcd_arm <= 1'b0;
      pm_arm  <= 1'b0;
      pm_pol  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      if (do_wr) begin
        if (bad_osc) begin
          cfg_err <= 1'b1;
        end else begin
          osc_off <= wr_data[B_OSC_OFF];
          lcd_arm <= wr_data[B_LCD_ARM];
          pm_arm  <= wr_data[B_PM_ARM];
          if (bad_pol) cfg_err <= 1'b1;
          else         pm_pol  <= wr_data[B_POL];
        end
      end else if (clr_arms) begin
        lcd_arm <= 1'b0;
        pm_arm  <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[B_OSC_OFF] = osc_off;
    rd_data[B_LCD_ARM] = lcd_arm;
    rd_data[B_PM_ARM]  = pm_arm;
    rd_data[B_POL]     = pm_pol;
  end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int OSC_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pin_rise,
  input  logic [1:0] pin_fall,
  input  logic       pm_rise,
  input  logic       pm_fall,
  input  logic       rtc_tick,
  input  logic       lcd_arm,
  input  logic       pm_arm,
  input  logic       pm_pol,
  input  logic       osc_off,
  output lps_state_e state,
  output logic       wake
);
  localparam int CW = $clog2(OSC_TICKS + 1);

  lps_state_e    nxt;
  logic [CW-1:0] tick_cnt;
  logic          pm_evt, exit_evt, enter_evt, last_tick;

  assign pm_evt    = pm_arm & (pm_pol ? pm_fall : pm_rise);
  assign exit_evt  = (|pin_fall) | pm_evt;
  assign enter_evt = (|pin_rise) & (lcd_arm | pm_arm);
  assign last_tick = rtc_tick & osc_off & (tick_cnt == CW'(OSC_TICKS - 1));

  always_comb begin
    nxt  = state;
    wake = 1'b0;
    unique case (state)
      ST_RUN:  if (enter_evt) nxt = ST_LP;
      ST_LP: begin
        if (exit_evt) begin
          nxt  = ST_RUN;
          wake = 1'b1;
        end else if (last_tick) begin
          nxt = ST_OFF;
        end
      end
      ST_OFF:  if (exit_evt) nxt = ST_WAKE;
      ST_WAKE: begin
        nxt  = ST_RUN;
        wake = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      tick_cnt <= '0;
    end else begin
      state <= nxt;
      if (state != ST_LP)             tick_cnt <= '0;
      else if (rtc_tick && osc_off)   tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int OSC_TICKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sel_pin,
  input  logic       req_pin,
  input  logic       pm_in,
  input  logic       rtc_tick,
  output logic       reg_en,
  output logic       osc_en,
  output logic       lcd_lp_en,
  output logic [1:0] mode,
  output logic       cfg_err
);
  logic [2:0] s_rise, s_fall;
  logic       osc_off, lcd_arm, pm_arm, pm_pol, wake;
  lps_state_e state;

  lps_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pm_in, req_pin, sel_pin}),
    .rise(s_rise),
    .fall(s_fall)
  );

  lps_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .allow_wr(state == ST_RUN),
    .clr_arms(wake),
    .rd_data (rd_data),
    .osc_off (osc_off),
    .lcd_arm (lcd_arm),
    .pm_arm  (pm_arm),
    .pm_pol  (pm_pol),
    .cfg_err (cfg_err)
  );

  lps_fsm #(.OSC_TICKS(OSC_TICKS)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pin_rise(s_rise[1:0]),
    .pin_fall(s_fall[1:0]),
    .pm_rise (s_rise[2]),
    .pm_fall (s_fall[2]),
    .rtc_tick(rtc_tick),
    .lcd_arm (lcd_arm),
    .pm_arm  (pm_arm),
    .pm_pol  (pm_pol),
    .osc_off (osc_off),
    .state   (state),
    .wake    (wake)
  );

  assign reg_en    = (state == ST_RUN);
  assign osc_en    = (state != ST_OFF);
  assign lcd_lp_en = (state != ST_RUN) & lcd_arm;
  always_comb begin
    unique case (state)
      ST_RUN:  mode = MODE_RUN;
      ST_OFF:  mode = MODE_OFF;
      default: mode = MODE_LP;
    endcase
  end
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       reg_en,
  input logic       osc_en,
  input logic [1:0] mode,
  input logic       cfg_err
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:5] == 3'b000 && rd_data[2] == 1'b0);

  a_r3_err_after_write: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(wr_en));

  a_r5_entry_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_en) |-> $past(rd_data[3] | rd_data[1]));

  a_r7_arms_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_en) |-> (rd_data[3] == 1'b0 && rd_data[1] == 1'b0));

  a_r10_off_state: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (!osc_en && !reg_en));

  a_r11_osc_first: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_en) |-> $past(osc_en));

  a_r11_no_reg_without_osc: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !reg_en);
endmodule

bind lps_ctrl lps_ctrl_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_data(rd_data),
  .reg_en (reg_en),
  .osc_en (osc_en),
  .mode   (mode),
  .cfg_err(cfg_err)
);

// File: tb/lps_ctrl_tb_top.sv
module lps_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sel_pin = 1'b0, req_pin = 1'b0, pm_in = 1'b0, rtc_tick = 1'b0;
  logic       reg_en, osc_en, lcd_lp_en, cfg_err;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  logic [7:0] cur = '0;

  always #4 clk = ~clk;

  lps_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sel_pin(sel_pin), .req_pin(req_pin), .pm_in(pm_in), .rtc_tick(rtc_tick),
    .reg_en(reg_en), .osc_en(osc_en), .lcd_lp_en(lcd_lp_en), .mode(mode),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // returns {reg_en, osc_en, lcd_lp_en, mode}
  function automatic logic [4:0] outs();
    return {reg_en, osc_en, lcd_lp_en, mode};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cyc(50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [7:0] exp_v;
    logic       exp_e, arm;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 outputs", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    chk("R1 cfg_err", cfg_err, 0);

    // R2 R3 R4 sweep over every write value
    for (int d = 0; d < 256; d++) begin
      arm = d[3] | d[1];
      if (d[4] && !arm) begin
        exp_v = cur; exp_e = 1'b1;
      end else begin
        exp_e = arm && (d[0] != cur[0]);
        exp_v = {3'b000, d[4], d[3], 1'b0, d[1], exp_e ? cur[0] : d[0]};
      end
      wr(8'(d));
      chk("R2 R3 R4 readback", rd_data, exp_v);
      chk("R3 R4 cfg_err", cfg_err, exp_e);
      cur = exp_v;
      cyc(1);
      chk("R3 cfg_err one cycle", cfg_err, 0);
    end
    wr(8'h00);
    chk("R2 clear", rd_data, 8'h00);

    // R5 unarmed: rising edge has no effect
    sel_pin = 1'b1; cyc(4);
    chk("R5 unarmed no entry", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    sel_pin = 1'b0; cyc(4);

    // R5 R9 R13 entry via req_pin with LCD arm
    wr(8'h08);
    req_pin = 1'b1; cyc(2);
    chk("R13 not yet", reg_en, 1);
    cyc(1);
    chk("R13 R5 entry on third edge", outs(), {1'b0, 1'b1, 1'b1, 2'b01});
    chk("R9 lcd_lp_en", lcd_lp_en, 1);
    // R12 write ignored in ULP
    wr(8'h02);
    chk("R12 write ignored", rd_data, 8'h08);
    chk("R12 no err", cfg_err, 0);
    // R6 R7 exit on falling req_pin
    req_pin = 1'b0; cyc(4);
    chk("R6 exit", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    chk("R7 arms cleared", rd_data, 8'h00);

    // R8 polarity 0: rising pm wakes
    wr(8'h02);
    sel_pin = 1'b1; cyc(4);
    chk("R5 entry via sel", mode, 2'b01);
    chk("R9 lcd off with pm arm only", lcd_lp_en, 0);
    pm_in = 1'b1; cyc(4);
    chk("R8 pol0 rise wakes", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    chk("R7 pm arm cleared", rd_data, 8'h00);
    sel_pin = 1'b0; pm_in = 1'b0; cyc(4);
    chk("R6 fall in normal no effect", mode, 2'b00);

    // R8 polarity 1: rising pm ignored, falling wakes
    wr(8'h01);
    wr(8'h03);
    chk("R4 pol kept readback", rd_data, 8'h03);
    sel_pin = 1'b1; cyc(4);
    chk("R5 entry pol1", mode, 2'b01);
    pm_in = 1'b1; cyc(4);
    chk("R8 wrong direction no wake", mode, 2'b01);
    pm_in = 1'b0; cyc(4);
    chk("R8 pol1 fall wakes", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    chk("R7 pol kept", rd_data, 8'h01);
    sel_pin = 1'b0; cyc(4);

    // R8 no pm wake when only LCD armed
    wr(8'h09);
    sel_pin = 1'b1; cyc(4);
    chk("R5 R9 lcd entry", outs(), {1'b0, 1'b1, 1'b1, 2'b01});
    pm_in = 1'b1; cyc(4);
    pm_in = 1'b0; cyc(4);
    chk("R8 pm unarmed no wake", mode, 2'b01);
    sel_pin = 1'b0; cyc(4);
    chk("R6 exit via sel", outs(), {1'b1, 1'b1, 1'b0, 2'b00});

    // R10 R11 shutdown and ordered wake
    wr(8'h19);
    req_pin = 1'b1; cyc(4);
    chk("R10 ULP before ticks", outs(), {1'b0, 1'b1, 1'b1, 2'b01});
    rtc_tick = 1'b1; cyc(1); rtc_tick = 1'b0;
    cyc(1);
    chk("R10 after one tick", outs(), {1'b0, 1'b1, 1'b1, 2'b01});
    rtc_tick = 1'b1; cyc(1); rtc_tick = 1'b0;
    chk("R10 shutdown after two ticks", outs(), {1'b0, 1'b0, 1'b1, 2'b10});
    cyc(3);
    chk("R10 stays shutdown", mode, 2'b10);
    req_pin = 1'b0; cyc(3);
    chk("R11 osc first", outs(), {1'b0, 1'b1, 1'b1, 2'b01});
    cyc(1);
    chk("R11 regulator next", outs(), {1'b1, 1'b1, 1'b0, 2'b00});
    chk("R7 osc_off kept", rd_data, 8'h11);

    finish_run();
  end
endmodule